// File: doc/BRIEF.md
# Routed Reloading Interval Timer

This block is a periodic down-counting timer clocked by an external tick-enable strobe. Software programs a 28-bit period, a counting enable and an interrupt enable through one control word. Every time the period runs out, the timer raises a sticky expiry flag and starts the next period at once, with no idle tick in between.

A write-only acknowledge register clears the flag, restarts the current period, or does both. A small routing register sends the resulting interrupt to one of four processor cores, either as a normal interrupt or as a fast interrupt. The block drives the combined interrupt line, a one-hot core select, a fast-select bit and per-core interrupt and fast-interrupt lines. The registers sit on a simple word-wide write strobe with a combinational read path.

Top module: `rit_top`

## Requirements
- R1: After synchronous reset, the control word (offset 0x34) and the route register (offset 0x24) read 0, the counter is stopped and every interrupt output is low.
- R2: A control write stores bit 29 as interrupt enable, bit 28 as counting enable and bits 27:0 as the period. A read of the control word returns the flag in bit 31, 0 in bit 30 and the stored fields in place. Bits 31 and 30 of a control write have no effect.
- R3: With counting enabled and a period N > 0, the flag sets on the N-th tick after the control write. The counter then reloads N and the flag sets again after N more ticks.
- R4: While counting is disabled, ticks do not change the count and the flag is never set. A control write with enable clear stops counting and leaves the flag as it was.
- R5: With counting enabled and a period of 0, the timer never expires.
- R6: The acknowledge register (offset 0x38) reads 0. Writing it with bit 31 set clears the flag.
- R7: An acknowledge with bit 30 set while counting is enabled reloads the period, so the next expiry comes N ticks later. A tick in the same cycle is discarded. While counting is disabled, bit 30 is ignored.
- R8: If a flag-clearing acknowledge and an expiry fall in the same cycle, the flag ends up set.
- R9: timer_irq is high exactly while both the flag and the interrupt enable are set.
- R10: The route register keeps bits 2:0, and the other bits of the write are dropped. Bits 1:0 pick core 0..3 (core_sel one-hot), and bit 2 set routes to core_fiq, bit 2 clear to core_irq. At most one of the eight per-core lines is high, and only while timer_irq is high.
- R11: A control write with enable set during a running period restarts counting from the newly written period. A tick in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick strobe, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| timer_irq | output | 1 | Combined timer interrupt |
| core_sel | output | 4 | One-hot target core from the route register |
| fiq_sel | output | 1 | Route selects the fast interrupt |
| core_irq | output | 4 | Per-core normal interrupt |
| core_fiq | output | 4 | Per-core fast interrupt |

## Verification
Register writes, tick strobes and acknowledges act on the rising edge where they are sampled. The flag, timer_irq and the per-core lines therefore change one edge after the stimulus, and reg_rdata follows combinationally from the registered state and the address. The bench drives inputs on the falling edge. Its behavioural model advances on the same rising edge as the design, and every output is compared shortly after that edge. Directed reads set the address between edges and sample before the next rising edge. The tick counts in the directed sequence put each expiry on a known edge, so same-cycle collisions of tick, acknowledge and control write land exactly where intended.

// File: rtl/rit_pkg.sv
`timescale 1ns/1ps
package rit_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int VAL_W   = 28;
    localparam int NCORE   = 4;
    localparam int CORE_W  = $clog2(NCORE);
    localparam int ROUTE_W = CORE_W + 1;

    // bit positions that software decodes
    localparam int FLAG_BIT    = 31;
    localparam int RESTART_BIT = 30;
    localparam int IE_BIT      = 29;
    localparam int EN_BIT      = 28;

    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h38;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CTRL,
        OP_ACK,
        OP_ROUTE
    } op_e;

    typedef struct packed {
        logic             ie;
        logic             en;
        logic [VAL_W-1:0] period;
    } ctl_t;

    typedef struct packed {
        logic              fiq;
        logic [CORE_W-1:0] core;
    } route_t;

    function automatic op_e decode_op(input logic [ADDR_W-1:0] a);
        op_e o;
        case (a)
            OFS_CTRL:  o = OP_CTRL;
            OFS_ACK:   o = OP_ACK;
            OFS_ROUTE: o = OP_ROUTE;
            default:   o = OP_NONE;
        endcase
        return o;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctl_t c, input logic flag);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[VAL_W-1:0]   = c.period;
        w[EN_BIT]      = c.en;
        w[IE_BIT]      = c.ie;
        w[FLAG_BIT]    = flag;
        return w;
    endfunction

endpackage

// File: rtl/rit_regs.sv
`timescale 1ns/1ps
module rit_regs
    import rit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output ctl_t              ctl,
    output route_t            route,
    output logic              ctrl_wr,
    output logic              wr_en,
    output logic [VAL_W-1:0]  wr_period,
    output logic              ack_clr,
    output logic              restart,
    output logic [DATA_W-1:0] rdata
);

    op_e wop;
    op_e rop;

    assign wop = wr ? decode_op(addr) : OP_NONE;
    assign rop = decode_op(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            route <= '0;
        end else begin
            if (wop == OP_CTRL) begin
                ctl.ie     <= wdata[IE_BIT];
                ctl.en     <= wdata[EN_BIT];
                ctl.period <= wdata[VAL_W-1:0];
            end
            if (wop == OP_ROUTE) begin
                route <= route_t'(wdata[ROUTE_W-1:0]);
            end
        end
    end

    assign ctrl_wr   = (wop == OP_CTRL);
    assign wr_en     = wdata[EN_BIT];
    assign wr_period = wdata[VAL_W-1:0];
    assign ack_clr   = (wop == OP_ACK) && wdata[FLAG_BIT];
    assign restart   = (wop == OP_ACK) && wdata[RESTART_BIT] && ctl.en;

    always_comb begin
        case (rop)
            OP_CTRL:  rdata = pack_ctrl(ctl, flag);
            OP_ROUTE: rdata = DATA_W'(route);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/rit_counter.sv
`timescale 1ns/1ps
module rit_counter
    import rit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic [VAL_W-1:0] period,
    input  logic             ctrl_wr,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_period,
    input  logic             restart,
    output logic             expire
);

    logic [VAL_W-1:0] cnt_q;
    logic             step;
    logic             last;

    assign step   = !ctrl_wr && !restart && tick && en && (period != '0);
    assign last   = (cnt_q <= VAL_W'(1));
    assign expire = step && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctrl_wr) begin
            if (wr_en) begin
                cnt_q <= wr_period;
            end
        end else if (restart) begin
            cnt_q <= period;
        end else if (step) begin
            cnt_q <= last ? period : cnt_q - VAL_W'(1);
        end
    end

endmodule

// File: rtl/rit_flag.sv
`timescale 1ns/1ps
module rit_flag (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic ack_clr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (ack_clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && ie;

endmodule

// File: rtl/rit_route.sv
`timescale 1ns/1ps
module rit_route
    import rit_pkg::*;
(
    input  logic             irq,
    input  route_t           route,
    output logic [NCORE-1:0] core_sel,
    output logic             fiq_sel,
    output logic [NCORE-1:0] core_irq,
    output logic [NCORE-1:0] core_fiq
);

    assign fiq_sel = route.fiq;

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        assign core_sel[i] = (route.core == CORE_W'(i));
        assign core_irq[i] = irq && core_sel[i] && !route.fiq;
        assign core_fiq[i] = irq && core_sel[i] &&  route.fiq;
    end

endmodule

// File: rtl/rit_top.sv
`timescale 1ns/1ps
module rit_top
    import rit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              timer_irq,
    output logic [NCORE-1:0]  core_sel,
    output logic              fiq_sel,
    output logic [NCORE-1:0]  core_irq,
    output logic [NCORE-1:0]  core_fiq
);

    ctl_t             ctl;
    route_t           route;
    logic             ctrl_wr;
    logic             wr_en;
    logic [VAL_W-1:0] wr_period;
    logic             ack_clr;
    logic             restart;
    logic             expire;
    logic             flag;

    rit_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .flag      (flag),
        .ctl       (ctl),
        .route     (route),
        .ctrl_wr   (ctrl_wr),
        .wr_en     (wr_en),
        .wr_period (wr_period),
        .ack_clr   (ack_clr),
        .restart   (restart),
        .rdata     (reg_rdata)
    );

    rit_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .en        (ctl.en),
        .period    (ctl.period),
        .ctrl_wr   (ctrl_wr),
        .wr_en     (wr_en),
        .wr_period (wr_period),
        .restart   (restart),
        .expire    (expire)
    );

    rit_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .ack_clr (ack_clr),
        .ie      (ctl.ie),
        .flag    (flag),
        .irq     (timer_irq)
    );

    rit_route u_route (
        .irq      (timer_irq),
        .route    (route),
        .core_sel (core_sel),
        .fiq_sel  (fiq_sel),
        .core_irq (core_irq),
        .core_fiq (core_fiq)
    );

endmodule

// File: rtl/rit_chk.sv
`timescale 1ns/1ps
module rit_chk
    import rit_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [VAL_W-1:0] period,
    input logic [VAL_W-1:0] cnt,
    input logic             ctrl_wr,
    input logic             ack_clr,
    input logic             expire,
    input logic             flag,
    input logic             timer_irq,
    input logic [NCORE-1:0] core_irq,
    input logic [NCORE-1:0] core_fiq
);

    // R8
    expire_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    // R6
    ack_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_clr && !expire) |=> !flag);

    // R5
    zero_period_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en && period == '0 && !flag && !ctrl_wr) |=> !flag);

    // R3
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= period));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !ctrl_wr) |=> $stable(cnt));

    // R10
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_irq, core_fiq}));

    // R9
    irq_delivered_chk: assert property (@(posedge clk) disable iff (rst)
        timer_irq == (|{core_irq, core_fiq}));

endmodule

bind rit_top rit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl.en),
    .period    (ctl.period),
    .cnt       (u_cnt.cnt_q),
    .ctrl_wr   (ctrl_wr),
    .ack_clr   (ack_clr),
    .expire    (expire),
    .flag      (flag),
    .timer_irq (timer_irq),
    .core_irq  (core_irq),
    .core_fiq  (core_fiq)
);

// File: tb/tb_rit_top.sv
`timescale 1ns/1ps
module tb_rit_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        timer_irq;
    logic [3:0]  core_sel;
    logic        fiq_sel;
    logic [3:0]  core_irq;
    logic [3:0]  core_fiq;

    rit_top dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .timer_irq (timer_irq),
        .core_sel  (core_sel),
        .fiq_sel   (fiq_sel),
        .core_irq  (core_irq),
        .core_fiq  (core_fiq)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit cmp_on = 0;
    bit done   = 0;

    // behavioural reference state
    bit          m_en, m_ie, m_flag;
    int unsigned m_val, m_cnt;
    int unsigned m_route;

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a == 8'h34)
            return {m_flag, 1'b0, m_ie, m_en, m_val[27:0]};
        else if (a == 8'h24)
            return {29'h0, m_route[2:0]};
        else
            return 32'h0;
    endfunction

    function automatic logic [3:0] exp_lines(input bit want_fiq);
        logic [3:0] v;
        v = 4'h0;
        if (m_ie && m_flag && (m_route[2] == want_fiq))
            v[m_route[1:0]] = 1'b1;
        return v;
    endfunction

    always @(posedge clk) begin
        bit ex, cw, aw, rw;
        cyc++;
        if (rst) begin
            m_en = 0; m_ie = 0; m_flag = 0; m_val = 0; m_cnt = 0; m_route = 0;
        end else begin
            ex = 0;
            cw = reg_wr && reg_addr == 8'h34;
            aw = reg_wr && reg_addr == 8'h38;
            rw = reg_wr && reg_addr == 8'h24;
            if (cw) begin
                m_ie  = reg_wdata[29];
                m_en  = reg_wdata[28];
                m_val = reg_wdata[27:0];
                if (m_en) m_cnt = m_val;
            end else if (aw && reg_wdata[30] && m_en) begin
                m_cnt = m_val;
            end else if (tick_en && m_en && m_val != 0) begin
                if (m_cnt <= 1) begin
                    ex = 1;
                    m_cnt = m_val;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (aw && reg_wdata[31]) m_flag = 0;
            if (ex) m_flag = 1;
            if (rw) m_route = reg_wdata[2:0];
        end
        if (cyc >= 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
        if (cmp_on) begin
            #1;
            check32("R9 timer_irq", {31'h0, timer_irq}, {31'h0, m_ie & m_flag});
            check32("R10 core_irq", {28'h0, core_irq}, {28'h0, exp_lines(1'b0)});
            check32("R10 core_fiq", {28'h0, core_fiq}, {28'h0, exp_lines(1'b1)});
            check32("R10 core_sel", {28'h0, core_sel}, 32'h1 << m_route[1:0]);
            check32("R10 fiq_sel", {31'h0, fiq_sel}, {31'h0, m_route[2]});
            check32("R2 reg_rdata", reg_rdata, exp_rd(reg_addr));
        end
    end

    // all tasks start and end on a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 0);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick_en = tk;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #0.5;
        check32(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;
        // R1 reset state
        rd(8'h34, 32'h0, "R1 ctrl after reset");
        rd(8'h24, 32'h0, "R1 route after reset");
        check32("R1 irq after reset", {31'h0, timer_irq}, 32'h0);

        // R2 / R3 basic period of 5
        wr(8'h34, 32'h3000_0005);
        rd(8'h34, 32'h3000_0005, "R2 ctrl readback");
        ticks(4);
        rd(8'h34, 32'h3000_0005, "R3 no early expiry");
        ticks(1);
        rd(8'h34, 32'hB000_0005, "R3 flag on 5th tick");
        check32("R10 core0 irq", {28'h0, core_irq}, 32'h1);

        // R6 acknowledge
        rd(8'h38, 32'h0, "R6 ack reads 0");
        wr(8'h38, 32'h8000_0000);
        rd(8'h34, 32'h3000_0005, "R6 flag cleared");
        check32("R9 irq low after clear", {31'h0, timer_irq}, 32'h0);

        // R10 route to fast interrupt of core 2, R3 periodic
        wr(8'h24, 32'h6);
        rd(8'h24, 32'h6, "R10 route readback");
        ticks(5);
        rd(8'h34, 32'hB000_0005, "R3 periodic expiry");
        check32("R10 core2 fiq", {28'h0, core_fiq}, 32'h4);
        check32("R10 no irq line", {28'h0, core_irq}, 32'h0);

        // R2 bits 31/30 ignored, R9 gating by interrupt enable
        wr(8'h34, 32'hD000_0005);
        rd(8'h34, 32'h9000_0005, "R2 flag kept, bit30 reads 0");
        check32("R9 irq masked", {31'h0, timer_irq}, 32'h0);

        // R8 clear and expiry in the same cycle
        wr(8'h38, 32'h8000_0000);
        rd(8'h34, 32'h1000_0005, "R6 clear before collision");
        ticks(4);
        wr(8'h38, 32'h8000_0000, 1);
        rd(8'h34, 32'h9000_0005, "R8 expiry wins");

        // R7 restart with a colliding tick
        wr(8'h34, 32'h3000_0005);
        wr(8'h38, 32'h8000_0000);
        ticks(3);
        wr(8'h38, 32'h4000_0000, 1);
        ticks(4);
        rd(8'h34, 32'h3000_0005, "R7 restart delays expiry");
        ticks(1);
        rd(8'h34, 32'hB000_0005, "R7 expiry after restart");

        // R4 disabled counting, R7 restart ignored while disabled
        wr(8'h34, 32'h2000_0003);
        wr(8'h38, 32'h8000_0000);
        ticks(10);
        rd(8'h34, 32'h2000_0003, "R4 no expiry while disabled");
        wr(8'h38, 32'h4000_0000);
        ticks(5);
        rd(8'h34, 32'h2000_0003, "R7 restart ignored when disabled");
        wr(8'h34, 32'h3000_0003);
        ticks(3);
        rd(8'h34, 32'hB000_0003, "R4 counting resumes");
        check32("R10 core2 fiq again", {28'h0, core_fiq}, 32'h4);

        // R11 rewrite while running, with a colliding tick
        wr(8'h38, 32'h8000_0000);
        wr(8'h34, 32'h3000_0004);
        ticks(2);
        wr(8'h34, 32'h3000_0002, 1);
        ticks(1);
        rd(8'h34, 32'h3000_0002, "R11 new period started");
        ticks(1);
        rd(8'h34, 32'hB000_0002, "R11 expiry on new period");

        // R5 zero period
        wr(8'h34, 32'h3000_0000);
        wr(8'h38, 32'h8000_0000);
        ticks(50);
        rd(8'h34, 32'h3000_0000, "R5 zero period never expires");
        check32("R5 irq low", {31'h0, timer_irq}, 32'h0);

        // R10 upper bits dropped, core selection
        wr(8'h24, 32'hFFFF_FFF9);
        rd(8'h24, 32'h1, "R10 route keeps 3 bits");
        wr(8'h34, 32'h3000_0001);
        ticks(1);
        check32("R10 core1 irq", {28'h0, core_irq}, 32'h2);
        wr(8'h24, 32'h3);
        check32("R10 core3 irq", {28'h0, core_irq}, 32'h8);
        check32("R10 core3 sel", {28'h0, core_sel}, 32'h8);

        // R1 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(8'h34, 32'h0, "R1 ctrl after second reset");
        rd(8'h24, 32'h0, "R1 route after second reset");
        check32("R1 irq after second reset", {31'h0, timer_irq}, 32'h0);
        ticks(3);
        rd(8'h34, 32'h0, "R1 stopped after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule